// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block drives an asynchronous DRAM whose array holds 2048 rows of 2048 columns and whose row and column address halves share one 11-bit address bus. A client presents a 22-bit word address together with a read/write flag and write data. The sequencer puts the row half on the bus and lowers the row strobe, then puts the column half on the bus and lowers the column strobe. For a write it drives the data bus with write enable low. For a read it lowers output enable together with the column strobe and samples the data bus once both access latencies have elapsed. Every minimum interval is given in nanoseconds and turned into a whole number of clock cycles by rounding up. At a 10 ns clock these are: 6 cycles from row strobe to data, 11 between row openings, 2 from column strobe to data, and 4 between column starts.

After an access the row stays open, so a later access to the same row needs only a column cycle (page mode). An access to another row first raises the row strobe and waits out the row-cycle minimum. A refresh timer spreads the full 8 ms refresh window over all 2048 rows, which gives one row every 390 cycles. Each refresh is a row-strobe-only cycle on an internal row counter. A pending refresh blocks new requests and starts as soon as the current access ends.

Top module: `dram_seq`

## Requirements
- R1: After reset, all four strobes (row, column, write enable, output enable) are high, the data bus is not driven, and `req_ready` is 1.
- R2: The row strobe falls with address bits [21:11] on `dram_addr`. The column strobe falls with address bits [10:0] on `dram_addr`.
- R3: Two falling edges of the row strobe are at least 11 clock cycles apart, whether they come from accesses or refreshes.
- R4: Two falling edges of the column strobe within one row-strobe-low period are at least 4 cycles apart.
- R5: A read returns on `rd_data` the word stored at its address, with a one-cycle `rd_valid` pulse. The data is sampled no sooner than 6 cycles after the row strobe fell and 2 cycles after the column strobe fell. Reads complete in issue order.
- R6: An access to the currently open row produces a column cycle only, with no new row opening.
- R7: An access to a row other than the open one raises the row strobe and then opens the new row.
- R8: A refresh is a row-strobe low period with no column strobe. Successive refreshes address rows 0, 1, 2, … in order, and the row number wraps modulo 2048.
- R9: A refresh request becomes pending every 390 cycles. While it is pending `req_ready` is 0, and it is serviced once the running access completes, so refreshes never fall more than about 40 cycles behind their period.
- R10: During a write column cycle, write enable is low, output enable is high and the data bus is driven. During a read column cycle, output enable is low and the data bus is released.
- R11: The column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns by default |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:11], column in [10:0] |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge when both valid and ready are 1 |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | 1 while the sequencer drives the data bus |
| dram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
Some rules are checked by the bound checker on every cycle. These are the strobe spacings (row and column), that the column strobe only falls inside a row-strobe low period, that read data never arrives before either latency, that `rd_valid` is a single-cycle pulse, and that output enable and write enable never overlap with the bus direction. Other behaviour can only be shown by the bench scenarios. The bench's DRAM model returns junk before both latencies have passed, so it shows that correct data arrives, and that the row and column halves land in the right places. The scenarios also show that page hits avoid a new row opening and that a row miss reopens. Refreshes are shown to walk the rows in order and to keep their period under continuous traffic.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int AGE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_COL,
    ST_DATA,
    ST_REF,
    ST_RHOLD
  } seq_state_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/dram_seq_age.sv
module dram_seq_age #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] age
);
  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '1;
    end else if (clr) begin
      age <= '0;
    end else if (age != '1) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/dram_seq_refresh.sv
module dram_seq_refresh #(
  parameter int PERIOD = 390,
  parameter int ROW_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      pend <= tick | (pend & ~ack);
      if (ack) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int HALF_W        = 11,
  parameter int DQ_W          = 8,
  parameter int CLK_NS        = 10,
  parameter int T_RAC_NS      = 60,
  parameter int T_RC_NS       = 110,
  parameter int T_CAC_NS      = 15,
  parameter int T_PC_NS       = 35,
  parameter int REF_WINDOW_NS = 8000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DQ_W-1:0]     req_wdata,
  output logic                req_ready,
  output logic                rd_valid,
  output logic [DQ_W-1:0]     rd_data,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [DQ_W-1:0]     dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DQ_W-1:0]     dram_dq_in
);
  localparam int RAC_CYC = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int RC_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int CAC_CYC = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int PC_CYC  = ns_to_cyc(T_PC_NS, CLK_NS);
  localparam int REF_CYC = REF_WINDOW_NS / (CLK_NS * (1 << HALF_W));

  localparam logic [AGE_W-1:0] RAC_LIM = AGE_W'(RAC_CYC - 1);
  localparam logic [AGE_W-1:0] RC_LIM  = AGE_W'(RC_CYC - 1);
  localparam logic [AGE_W-1:0] CAC_LIM = AGE_W'(CAC_CYC - 1);
  localparam logic [AGE_W-1:0] PC_LIM  = AGE_W'(PC_CYC - 1);

  seq_state_t          state;
  logic                row_open;
  logic [HALF_W-1:0]   open_row;
  logic [HALF_W-1:0]   cur_row;
  logic [HALF_W-1:0]   cur_col;
  logic                cur_wr;
  logic [DQ_W-1:0]     cur_wd;

  logic [AGE_W-1:0]    ras_age;
  logic [AGE_W-1:0]    cas_age;
  logic                ras_go;
  logic                cas_go;
  logic                rc_ok;
  logic                pc_ok;
  logic                data_ok;
  logic                ref_pend;
  logic                ref_ack;
  logic [HALF_W-1:0]   ref_row;
  logic [HALF_W-1:0]   in_row;
  logic [HALF_W-1:0]   in_col;

  assign in_row = req_addr[2*HALF_W-1:HALF_W];
  assign in_col = req_addr[HALF_W-1:0];

  // interval bookkeeping: ages count edges since the last strobe fall
  dram_seq_age #(.W(AGE_W)) u_ras_age (
    .clk (clk),
    .rst (rst),
    .clr (ras_go),
    .age (ras_age)
  );

  dram_seq_age #(.W(AGE_W)) u_cas_age (
    .clk (clk),
    .rst (rst),
    .clr (cas_go),
    .age (cas_age)
  );

  dram_seq_refresh #(.PERIOD(REF_CYC), .ROW_W(HALF_W)) u_refresh (
    .clk  (clk),
    .rst  (rst),
    .ack  (ref_ack),
    .pend (ref_pend),
    .row  (ref_row)
  );

  assign rc_ok   = (ras_age >= RC_LIM);
  assign pc_ok   = (cas_age >= PC_LIM);
  assign data_ok = (ras_age >= RAC_LIM) && (cas_age >= CAC_LIM);

  always_comb begin
    ras_go  = 1'b0;
    cas_go  = 1'b0;
    ref_ack = 1'b0;
    case (state)
      ST_OPEN, ST_REF: ras_go  = dram_ras_n && rc_ok;
      ST_COL:          cas_go  = pc_ok;
      ST_RHOLD:        ref_ack = (ras_age >= RAC_LIM);
      default: ;
    endcase
  end

  assign req_ready = (state == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      row_open    <= 1'b0;
      open_row    <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      cur_wr      <= 1'b0;
      cur_wd      <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            dram_ras_n <= 1'b1;
            row_open   <= 1'b0;
            state      <= ST_REF;
          end else if (req_valid) begin
            cur_row <= in_row;
            cur_col <= in_col;
            cur_wr  <= req_write;
            cur_wd  <= req_wdata;
            if (row_open && (in_row == open_row)) begin
              state <= ST_COL;
            end else begin
              dram_ras_n <= 1'b1;
              row_open   <= 1'b0;
              state      <= ST_OPEN;
            end
          end
        end
        ST_OPEN: begin
          if (ras_go) begin
            dram_addr  <= cur_row;
            dram_ras_n <= 1'b0;
            row_open   <= 1'b1;
            open_row   <= cur_row;
            state      <= ST_COL;
          end
        end
        ST_COL: begin
          if (cas_go) begin
            dram_addr   <= cur_col;
            dram_cas_n  <= 1'b0;
            dram_we_n   <= ~cur_wr;
            dram_oe_n   <= cur_wr;
            dram_dq_oe  <= cur_wr;
            dram_dq_out <= cur_wd;
            state       <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (data_ok) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!cur_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            state <= ST_IDLE;
          end
        end
        ST_REF: begin
          if (ras_go) begin
            dram_addr  <= ref_row;
            dram_ras_n <= 1'b0;
            state      <= ST_RHOLD;
          end
        end
        ST_RHOLD: begin
          if (ref_ack) begin
            dram_ras_n <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int RC_CYC  = 11,
  parameter int PC_CYC  = 4,
  parameter int RAC_CYC = 6,
  parameter int CAC_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe,
  input logic rd_valid
);
  logic [7:0] ras_age;
  logic [7:0] cas_age;
  logic       ras_d;
  logic       cas_d;
  logic       ras_fell;
  logic       cas_fell;

  assign ras_fell = ras_d && !dram_ras_n;
  assign cas_fell = cas_d && !dram_cas_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_d   <= 1'b1;
      cas_d   <= 1'b1;
      ras_age <= '1;
      cas_age <= '1;
    end else begin
      ras_d <= dram_ras_n;
      cas_d <= dram_cas_n;
      if (ras_fell) ras_age <= 8'd1;
      else if (ras_age != '1) ras_age <= ras_age + 1'b1;
      if (cas_fell) cas_age <= 8'd1;
      else if (cas_age != '1) cas_age <= cas_age + 1'b1;
    end
  end

  AST_RAS_SPACING: assert property (@(posedge clk) disable iff (rst)
    ras_fell |-> (ras_age >= 8'(RC_CYC))); // R3
  AST_CAS_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cas_fell && !dram_ras_n && !ras_fell) |-> (cas_age >= 8'(PC_CYC))); // R4
  AST_RD_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((ras_age >= 8'(RAC_CYC)) && (cas_age >= 8'(CAC_CYC)))); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R5
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n); // R11
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!dram_we_n && !dram_oe_n)); // R10
  AST_BUS_DIR: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> dram_oe_n); // R10
endmodule

bind dram_seq dram_seq_chk #(
  .RC_CYC  (RC_CYC),
  .PC_CYC  (PC_CYC),
  .RAC_CYC (RAC_CYC),
  .CAC_CYC (CAC_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_dq_oe (dram_dq_oe),
  .rd_valid   (rd_valid)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [7:0]  dram_dq_out;
  logic        dram_dq_oe;
  logic [7:0]  dq_drv = 8'hEE;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dq_drv)
  );

  function automatic logic [7:0] dflt(input int a);
    return 8'((a ^ (a >> 11)) & 32'h7F);
  endfunction

  // ---------------- DRAM model (all activity at negedge) ----------------
  logic [7:0] mem [int];
  int  cyc = 0, ras_age = 1000, cas_age = 1000;
  int  last_ras = -1, last_cas = -1, last_ref = -1;
  int  row_l = 0, col_l = 0, exp_ref_row = 0;
  int  ref_cnt = 0, acc_opens = 0;
  bit  prev_ras = 1, prev_cas = 1, cas_in_period = 0;

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_ras && !dram_ras_n) begin
        if (last_ras >= 0) begin
          checks++;
          if (cyc - last_ras < 11) begin
            failures++;
            $display("FAIL R3 row strobe spacing %0d expected >= 11", cyc - last_ras);
          end
        end
        last_ras = cyc; row_l = int'(dram_addr); cas_in_period = 0; ras_age = 0;
      end else ras_age++;
      if (!prev_ras && dram_ras_n && !cas_in_period) begin
        checks++;
        if (row_l != exp_ref_row) begin
          failures++;
          $display("FAIL R8 refresh row %0d expected %0d", row_l, exp_ref_row);
        end
        exp_ref_row = (exp_ref_row + 1) % 2048;
        if (last_ref >= 0) begin
          checks++;
          if (cyc - last_ref > 430) begin
            failures++;
            $display("FAIL R9 refresh gap %0d expected <= 430", cyc - last_ref);
          end
        end
        last_ref = cyc; ref_cnt++;
      end
      if (prev_cas && !dram_cas_n) begin
        checks++;
        if (dram_ras_n) begin
          failures++;
          $display("FAIL R11 column strobe with row strobe high: ras_n=%0b expected 0", dram_ras_n);
        end
        if (cas_in_period) begin
          checks++;
          if (cyc - last_cas < 4) begin
            failures++;
            $display("FAIL R4 column strobe spacing %0d expected >= 4", cyc - last_cas);
          end
        end else acc_opens++;
        checks++;
        if (!dram_we_n) begin
          if (!(dram_dq_oe && dram_oe_n)) begin
            failures++;
            $display("FAIL R10 write cycle dq_oe=%0b oe_n=%0b expected 1 1", dram_dq_oe, dram_oe_n);
          end
        end else if (dram_dq_oe || dram_oe_n) begin
          failures++;
          $display("FAIL R10 read cycle dq_oe=%0b oe_n=%0b expected 0 0", dram_dq_oe, dram_oe_n);
        end
        cas_in_period = 1; last_cas = cyc; col_l = int'(dram_addr); cas_age = 0;
        if (!dram_we_n) mem[(row_l << 11) | col_l] = dram_dq_out;
      end else cas_age++;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
    dq_drv = (!dram_ras_n && !dram_cas_n && !dram_oe_n && ras_age >= 5 && cas_age >= 1)
             ? mem_rd((row_l << 11) | col_l) : 8'hEE;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expq [$];
  logic [7:0] shadow [int];

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R5 unexpected read data %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL R2 R5 read data %h expected %h", rd_data, e);
        end
      end
    end
  end

  task automatic issue(input bit wr, input int row, input int col, input logic [7:0] d);
    int a;
    a = (row << 11) | col;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 22'(a); req_wdata = d;
    if (wr) shadow[a] = d;
    else expq.push_back(shadow.exists(a) ? shadow[a] : dflt(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(req_ready && expq.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int o0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_int("R1 ras_n", int'(dram_ras_n), 1);
    check_int("R1 cas_n", int'(dram_cas_n), 1);
    check_int("R1 we_n", int'(dram_we_n), 1);
    check_int("R1 oe_n", int'(dram_oe_n), 1);
    check_int("R1 dq_oe", int'(dram_dq_oe), 0);
    check_int("R1 ready", int'(req_ready), 1);

    // R2 R10 write then read back
    issue(1, 5, 3, 8'h3C);
    issue(0, 5, 3, 8'h00);
    wait_idle();

    // R6 page hits on open row 5
    o0 = acc_opens; r0 = ref_cnt;
    issue(1, 5, 9, 8'h51);
    issue(0, 5, 9, 8'h00);
    issue(0, 5, 3, 8'h00);
    issue(0, 5, 100, 8'h00);
    wait_idle();
    if (ref_cnt == r0) check_int("R6 row openings on page hits", acc_opens - o0, 0);

    // R7 row miss
    o0 = acc_opens; r0 = ref_cnt;
    issue(0, 700, 1, 8'h00);
    wait_idle();
    if (ref_cnt == r0) check_int("R7 row openings on miss", acc_opens - o0, 1);

    // boundary rows and columns, back to back (R2 R3)
    issue(1, 2047, 2047, 8'h7A);
    issue(1, 0, 0, 8'h11);
    issue(0, 2047, 2047, 8'h00);
    issue(0, 0, 0, 8'h00);
    issue(0, 1024, 2047, 8'h00);
    wait_idle();

    // continuous traffic across refresh periods (R9)
    for (int i = 0; i < 120; i++) begin
      issue(i % 3 == 0, (i * 37) % 2048, (i * 101) % 2048, 8'((i * 5) & 8'h7F));
      issue(0, (i * 37) % 2048, (i * 101) % 2048, 8'h00);
    end
    wait_idle();

    // idle period, refreshes continue (R8)
    repeat (2000) @(negedge clk);
    checks++;
    if (ref_cnt < 6) begin
      failures++;
      $display("FAIL R8 refresh count %0d expected >= 6", ref_cnt);
    end
    check_int("R5 pending reads", expq.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule